// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is the two-wire (SMBus/I2C style) target that lets a system controller read and write a small bank of byte-wide configuration registers inside a clock-generation chip. The wire inputs are oversampled by the system clock, passed through two-flop synchronisers and turned into clock-edge, start and stop events. A protocol engine walks through the address, command, optional length and data phases. It acknowledges bytes by asserting a pull-down enable on the data line and serialises read data most significant bit first.

The command byte chooses the access mode. With its top bit set, the low seven bits are a register offset and a single indexed byte is accessed. With its top bit clear, the transfer is a block transfer that always starts at register 0. Block writes carry a length byte that the slave accepts and discards. Block reads begin with a length byte taken from the writable length register at index 12, followed by the data bytes. All register contents leave the block on one flat bus for the rest of the chip.

Top module: `clkcfg_smbus_slave`

## Requirements
- R1: A byte whose upper seven bits equal 69h (69h in bits 7:1, so D2h for a write and D3h for a read) is acknowledged by a low data line in the ninth clock. Any other address is not acknowledged, and the slave leaves the data line released for every later byte until the next start.
- R2: A command byte with bit 7 = 1 selects byte access at the offset in bits 6:0. A write that follows stores the next data byte at that offset. A read after a repeated start and address D3h returns that register, MSB first.
- R3: A command byte with bit 7 = 0 selects block access starting at register 0, whatever the value in bits 6:0.
- R4: In a block write, the byte after the command is a length byte that is acknowledged and not stored. Each following data byte is acknowledged and written to registers 0, 1, 2 … in turn. A stop after any whole byte leaves all later registers unchanged.
- R5: A block read returns the value of register 12 first, then registers 0, 1, 2 … in ascending order, MSB first, for as long as the master acknowledges.
- R6: The master's NACK after a read byte ends the transmission. The slave keeps the data line released until the next start or stop.
- R7: After reset the registers for indices 0 through 15 hold, in index order, 21 85 FF FF FF 00 00 48 83 25 03 06 0F FC A0 00 (hex). Bit 7 of register 0 equals the strap parameter, which is 0 by default. The data line is released.
- R8: Register 7 (value 48h) and bit 7 of register 0 are read-only. Writes to them are acknowledged, and the fixed bits keep their values. The other bits of register 0 take the written data.
- R9: Offsets 16 and above are acknowledged on write and the data is discarded. A read of such an offset, or of a block position past 15, returns 00h.
- R10: Writing register 12 changes the length byte that later block reads return. The new value takes effect without any other action.
- R11: The slave changes its pull-down enable only while SCL is low, and always releases it when a stop is detected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_in | input | 1 | Serial clock line as seen at the pin |
| sda_in | input | 1 | Serial data line as seen at the pin |
| sda_pull | output | 1 | 1 pulls the data line low (acknowledge or a 0 data bit) |
| cfg_regs | output | NUM_REGS*8 | All register contents, register i in bits 8i+7:8i |

## Verification
Two things happen on the same sampled rising edge of SCL: the acknowledge decision for a data byte and the register write that byte causes. The bench provokes both at once by writing the read-only identity register and the strap bit, and by writing register 12 just before a block read. A correct design acknowledges the byte in the following ninth clock. On every system clock it also keeps the register bus equal to the bench's behavioural model, which merges only the writable bits. The length byte of the next block read must show the value just written.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_END,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_MACK_END,
    ST_IGNORE
  } bus_st_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_COUNT,
    PH_DATA
  } rx_phase_e;

  // Power-up value of register idx; bit 7 of register 0 comes from a strap.
  function automatic logic [7:0] reg_default(input int idx, input logic strap);
    logic [7:0] v;
    case (idx)
      0:       v = {strap, 7'h21};
      1:       v = 8'h85;
      2, 3, 4: v = 8'hFF;
      7:       v = 8'h48;
      8:       v = 8'h83;
      9:       v = 8'h25;
      10:      v = 8'h03;
      11:      v = 8'h06;
      12:      v = 8'h0F;
      13:      v = 8'hFC;
      14:      v = 8'hA0;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  // Bits that bus writes may not change.
  function automatic logic [7:0] reg_ro_mask(input int idx, input int id_idx);
    logic [7:0] m;
    if (idx == id_idx)  m = 8'hFF;
    else if (idx == 0)  m = 8'h80;
    else                m = 8'h00;
    return m;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s    = scl_ff[STAGES-1];
  assign sda_s    = sda_ff[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfgbus_pkg::*;
#(
  parameter int   NUM_REGS = 16,
  parameter int   ID_IDX   = 7,
  parameter int   CNT_IDX  = 12,
  parameter int   PTR_W    = 7,
  parameter logic FS_STRAP = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [PTR_W-1:0]      wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [PTR_W-1:0]      rd_addr,
  output logic [7:0]            rd_data,
  output logic [7:0]            bcnt,
  output logic [NUM_REGS*8-1:0] regs_flat
);
  logic [7:0] regs_q [NUM_REGS];
  logic [7:0] regs_d [NUM_REGS];

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) begin
      regs_d[i] = regs_q[i];
      if (wr_en && (wr_addr == PTR_W'(i)))
        regs_d[i] = (regs_q[i] & reg_ro_mask(i, ID_IDX)) |
                    (wr_data & ~reg_ro_mask(i, ID_IDX));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= reg_default(i, FS_STRAP);
    end else begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= regs_d[i];
    end
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_addr == PTR_W'(i)) rd_data = regs_q[i];
  end

  assign bcnt = regs_q[CNT_IDX];

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
      assign regs_flat[g*8 +: 8] = regs_q[g];
    end
  endgenerate

  AST_ID_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> regs_q[ID_IDX] == $past(regs_q[ID_IDX])); // R8

  AST_STRAP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == '0) |=> regs_q[0][7] == $past(regs_q[0][7])); // R8

endmodule

// File: rtl/i2c_cfg_engine.sv
module i2c_cfg_engine
  import cfgbus_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         PTR_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_ev,
  input  logic             stop_ev,
  input  logic [7:0]       rd_data,
  input  logic [7:0]       bcnt,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [7:0]       wr_data,
  output logic [PTR_W-1:0] rd_addr,
  output logic             sda_pull
);
  bus_st_e    st_q, st_d;
  rx_phase_e  ph_q, ph_d;
  logic [3:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic [7:0] tx_q, tx_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic       blk_q, blk_d;
  logic       rd_q, rd_d;
  logic       lenfirst_q, lenfirst_d;
  logic       ack_q, ack_d;
  logic       pull_q, pull_d;
  logic       do_load;
  logic [7:0] byte_in;

  assign byte_in = {sh_q[6:0], sda_s};

  always_comb begin
    st_d       = st_q;
    ph_d       = ph_q;
    bit_d      = bit_q;
    sh_d       = sh_q;
    tx_d       = tx_q;
    ptr_d      = ptr_q;
    blk_d      = blk_q;
    rd_d       = rd_q;
    lenfirst_d = lenfirst_q;
    ack_d      = ack_q;
    pull_d     = pull_q;
    wr_en      = 1'b0;
    do_load    = 1'b0;

    if (stop_ev) begin
      st_d   = ST_IDLE;
      pull_d = 1'b0;
    end else if (start_ev) begin
      st_d   = ST_RX;
      ph_d   = PH_ADDR;
      bit_d  = '0;
      rd_d   = 1'b0;
      pull_d = 1'b0;
    end else begin
      case (st_q)
        ST_RX: if (scl_rise) begin
          sh_d  = byte_in;
          bit_d = bit_q + 4'd1;
          if (bit_q == 4'd7) begin
            st_d  = ST_RX_END;
            ack_d = 1'b1;
            case (ph_q)
              PH_ADDR: begin
                if (byte_in[7:1] != DEV_ADDR) ack_d = 1'b0;
                else if (byte_in[0]) begin
                  rd_d       = 1'b1;
                  lenfirst_d = blk_q;
                end else ph_d = PH_CMD;
              end
              PH_CMD: begin
                blk_d = ~byte_in[7];
                ptr_d = byte_in[7] ? byte_in[PTR_W-1:0] : '0;
                ph_d  = byte_in[7] ? PH_DATA : PH_COUNT;
              end
              PH_COUNT: ph_d = PH_DATA;
              default: begin
                wr_en = 1'b1;
                ptr_d = ptr_q + 1'b1;
              end
            endcase
          end
        end
        ST_RX_END: if (scl_fall) begin
          if (ack_q) begin
            pull_d = 1'b1;
            st_d   = ST_ACK;
          end else st_d = ST_IGNORE;
        end
        ST_ACK: if (scl_fall) begin
          bit_d = '0;
          if (rd_q) do_load = 1'b1;
          else begin
            pull_d = 1'b0;
            st_d   = ST_RX;
          end
        end
        ST_TX: begin
          if (scl_rise) bit_d = bit_q + 4'd1;
          if (scl_fall) begin
            if (bit_q == 4'd8) begin
              pull_d = 1'b0;
              st_d   = ST_MACK;
            end else begin
              tx_d   = {tx_q[6:0], 1'b0};
              pull_d = ~tx_q[6];
            end
          end
        end
        ST_MACK: if (scl_rise) st_d = sda_s ? ST_IGNORE : ST_MACK_END;
        ST_MACK_END: if (scl_fall) begin
          bit_d   = '0;
          do_load = 1'b1;
        end
        default: ;
      endcase
    end

    if (do_load) begin
      st_d = ST_TX;
      if (lenfirst_q) begin
        tx_d       = bcnt;
        lenfirst_d = 1'b0;
      end else begin
        tx_d  = rd_data;
        ptr_d = ptr_q + 1'b1;
      end
      pull_d = ~tx_d[7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      ph_q       <= PH_ADDR;
      bit_q      <= '0;
      sh_q       <= '0;
      tx_q       <= '0;
      ptr_q      <= '0;
      blk_q      <= 1'b0;
      rd_q       <= 1'b0;
      lenfirst_q <= 1'b0;
      ack_q      <= 1'b0;
      pull_q     <= 1'b0;
    end else begin
      st_q       <= st_d;
      ph_q       <= ph_d;
      bit_q      <= bit_d;
      sh_q       <= sh_d;
      tx_q       <= tx_d;
      ptr_q      <= ptr_d;
      blk_q      <= blk_d;
      rd_q       <= rd_d;
      lenfirst_q <= lenfirst_d;
      ack_q      <= ack_d;
      pull_q     <= pull_d;
    end
  end

  assign wr_addr  = ptr_q;
  assign wr_data  = byte_in;
  assign rd_addr  = ptr_q;
  assign sda_pull = pull_q;

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_pull); // R11

  AST_PULL_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s); // R11

  AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IGNORE) |-> !sda_pull); // R1

  AST_ACK_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACK) |-> sda_pull); // R1

  AST_WRITE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (scl_rise && st_q == ST_RX)); // R4

endmodule

// File: rtl/clkcfg_smbus_slave.sv
module clkcfg_smbus_slave #(
  parameter int         NUM_REGS = 16,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         ID_IDX   = 7,
  parameter int         CNT_IDX  = 12,
  parameter int         SYNC_STG = 2,
  parameter logic       FS_STRAP = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_in,
  input  logic                  sda_in,
  output logic                  sda_pull,
  output logic [NUM_REGS*8-1:0] cfg_regs
);
  localparam int PTR_W = 7;

  logic [1:0] rst_sync;
  logic       rst_i;
  logic       scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic       wr_en;
  logic [PTR_W-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data, bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  i2c_line_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_i), .scl_i(scl_in), .sda_i(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c_cfg_engine #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_eng (
    .clk(clk), .rst_n(rst_i), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .rd_data(rd_data), .bcnt(bcnt), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .sda_pull(sda_pull)
  );

  cfg_regfile #(
    .NUM_REGS(NUM_REGS), .ID_IDX(ID_IDX), .CNT_IDX(CNT_IDX),
    .PTR_W(PTR_W), .FS_STRAP(FS_STRAP)
  ) u_regs (
    .clk(clk), .rst_n(rst_i), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .bcnt(bcnt), .regs_flat(cfg_regs)
  );

endmodule

// File: tb/sim_clkcfg_smbus_slave.sv
`timescale 1ns/1ps
module sim_clkcfg_smbus_slave;
  localparam int N = 16;
  localparam int T = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic [N*8-1:0] cfg_regs;
  wire  sda_line = sda_m & ~sda_pull;

  int checks = 0;
  int errors = 0;
  bit settled = 1'b0;
  bit done = 1'b0;
  logic [7:0] model [N];
  logic [7:0] buf_d [24];

  always #4 clk = ~clk;

  clkcfg_smbus_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_pull(sda_pull), .cfg_regs(cfg_regs)
  );

  function automatic logic [N*8-1:0] model_flat();
    logic [N*8-1:0] v;
    for (int i = 0; i < N; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [N*8-1:0] act,
                     input logic [N*8-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model: registers compared on every clock while no byte is in flight.
  always @(negedge clk) begin
    if (settled && rst_n) chk(cfg_regs === model_flat(), "R4/R8 regbus", cfg_regs, model_flat());
  end

  task automatic model_write(input int idx, input logic [7:0] d);
    if (idx < N && idx != 7) begin
      if (idx == 0) model[0] = {model[0][7], d[6:0]};
      else          model[idx] = d;
    end
  endtask

  task automatic wait_t(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_t(T);
    scl_m = 1'b1; wait_t(T);
    sda_m = 1'b0; wait_t(T);
    scl_m = 1'b0; wait_t(T);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_t(T);
    scl_m = 1'b1; wait_t(T);
    sda_m = 1'b1; wait_t(2*T);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req,
                           input bit do_wr, input int widx);
    logic got;
    settled = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_t(T);
      scl_m = 1'b1; wait_t(T);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; wait_t(T);
    scl_m = 1'b1; wait_t(T/2);
    got = sda_line;
    chk(got == !exp_ack, req, {{(N*8-1){1'b0}}, got}, {{(N*8-1){1'b0}}, !exp_ack});
    if (do_wr) model_write(widx, b);
    wait_t(T/2);
    scl_m = 1'b0;
    settled = 1'b1;
  endtask

  task automatic recv_byte(input bit mnack, input logic [7:0] exp, input string req);
    logic [7:0] got;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_t(T);
      scl_m = 1'b1; wait_t(T/2);
      got[i] = sda_line;
      wait_t(T/2);
      scl_m = 1'b0;
    end
    chk(got === exp, req, {{(N*8-8){1'b0}}, got}, {{(N*8-8){1'b0}}, exp});
    sda_m = mnack; wait_t(T);
    scl_m = 1'b1; wait_t(T);
    scl_m = 1'b0;
    sda_m = 1'b1;
  endtask

  task automatic byte_write(input logic [6:0] off, input logic [7:0] d, input string req);
    bus_start();
    send_byte(8'hD2, 1'b1, "R1 addr ack", 1'b0, 0);
    send_byte({1'b1, off}, 1'b1, "R2 cmd ack", 1'b0, 0);
    send_byte(d, 1'b1, req, 1'b1, int'(off));
    bus_stop();
  endtask

  task automatic byte_read(input logic [6:0] off, input string req);
    logic [7:0] e;
    e = (int'(off) < N) ? model[off] : 8'h00;
    bus_start();
    send_byte(8'hD2, 1'b1, "R1 addr ack", 1'b0, 0);
    send_byte({1'b1, off}, 1'b1, "R2 cmd ack", 1'b0, 0);
    bus_start();
    send_byte(8'hD3, 1'b1, "R1 read addr ack", 1'b0, 0);
    recv_byte(1'b1, e, req);
    bus_stop();
  endtask

  task automatic block_write(input logic [7:0] cmd, input int cnt_byte, input int n);
    bus_start();
    send_byte(8'hD2, 1'b1, "R1 addr ack", 1'b0, 0);
    send_byte(cmd, 1'b1, "R3 block cmd ack", 1'b0, 0);
    send_byte(8'(cnt_byte), 1'b1, "R4 count ack", 1'b0, 0);
    for (int i = 0; i < n; i++) send_byte(buf_d[i], 1'b1, "R4 data ack", 1'b1, i);
    bus_stop();
  endtask

  task automatic block_read(input logic [7:0] cmd, input int n);
    bus_start();
    send_byte(8'hD2, 1'b1, "R1 addr ack", 1'b0, 0);
    send_byte(cmd, 1'b1, "R3 block cmd ack", 1'b0, 0);
    bus_start();
    send_byte(8'hD3, 1'b1, "R1 read addr ack", 1'b0, 0);
    recv_byte(n == 0, model[12], "R5/R10 length byte");
    for (int i = 0; i < n; i++)
      recv_byte(i == n-1, (i < N) ? model[i] : 8'h00, (i < N) ? "R5 block data" : "R9 past end");
    bus_stop();
  endtask

  initial begin
    model[0] = 8'h21; model[1] = 8'h85; model[2] = 8'hFF; model[3] = 8'hFF;
    model[4] = 8'hFF; model[5] = 8'h00; model[6] = 8'h00; model[7] = 8'h48;
    model[8] = 8'h83; model[9] = 8'h25; model[10] = 8'h03; model[11] = 8'h06;
    model[12] = 8'h0F; model[13] = 8'hFC; model[14] = 8'hA0; model[15] = 8'h00;
    wait_t(5);
    rst_n = 1'b1;
    wait_t(5);
    // R7 reset state
    chk(cfg_regs === model_flat(), "R7 reset regs", cfg_regs, model_flat());
    chk(sda_pull == 1'b0, "R7 reset line released", {{(N*8-1){1'b0}}, sda_pull}, '0);
    settled = 1'b1;

    byte_read(7'd9, "R2 byte read reg9");
    byte_write(7'd5, 8'h5A, "R2 byte write ack");
    byte_read(7'd5, "R2 readback reg5");

    // R8: read-only ID and strap bit, both acknowledged
    byte_write(7'd7, 8'h00, "R8 write ID ack");
    byte_write(7'd0, 8'hFE, "R8 write reg0 ack");
    byte_read(7'd0, "R8 reg0 readback");
    byte_read(7'd7, "R8 ID readback");

    // R9: out-of-range offset
    byte_write(7'h20, 8'h77, "R9 high offset write ack");
    byte_read(7'h20, "R9 high offset read");

    // R1: foreign address ignored until next start
    bus_start();
    send_byte(8'hA4, 1'b0, "R1 foreign addr nack", 1'b0, 0);
    send_byte(8'h85, 1'b0, "R1 ignored cmd", 1'b0, 0);
    send_byte(8'h11, 1'b0, "R1 ignored data", 1'b0, 0);
    bus_stop();

    // R4/R3: block write with nonzero offset bits, stopped after 3 of 5
    buf_d[0] = 8'h13; buf_d[1] = 8'hC4; buf_d[2] = 8'h9E;
    block_write(8'h05, 5, 3);

    // R5 block read with default length
    block_read(8'h00, 4);

    // R10: raise the length, read past register 15
    byte_write(7'd12, 8'h12, "R10 length write ack");
    block_read(8'h00, 18);

    // R6: NACK ends transmission, slave stays released
    bus_start();
    send_byte(8'hD2, 1'b1, "R1 addr ack", 1'b0, 0);
    send_byte(8'h84, 1'b1, "R2 cmd ack", 1'b0, 0);
    bus_start();
    send_byte(8'hD3, 1'b1, "R1 read addr ack", 1'b0, 0);
    recv_byte(1'b1, model[4], "R6 byte before nack");
    recv_byte(1'b1, 8'hFF, "R6 released after nack");
    bus_stop();
    chk(sda_pull == 1'b0, "R11 released after stop", {{(N*8-1){1'b0}}, sda_pull}, '0);

    wait_t(20);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule